// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the device side of a four-bank synchronous DRAM interface. On every rising clock edge it samples clock enable, chip select, the three active-low command strobes, the bank select and the address bus. It turns them into a command code and keeps, for each bank, whether a row is open and which row that is. Commands that break the bank rules are refused and reported on a one-cycle error flag. Refused commands leave every bank as it was.

Read and write commands also deliver the column address, packed to the width that the device organisation uses. Address bit 10 carries two meanings. On a read or write it asks for the addressed bank to close by itself when the burst ends. On a precharge it chooses between closing every bank and closing only the addressed one. The burst length is a fixed parameter. While clock enable is low, the whole tracker holds still.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: `cmd_code` shows, one cycle after each rising edge, the strobe code {ras_n,cas_n,we_n} sampled at that edge. The encodings are 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh and 000 load mode. The code reads 111 whenever `cs_n` or `cke` kept the command out.
- R2: While `cs_n` is high, no command takes effect and neither `cmd_err` nor `col_valid` is raised. A pending auto-precharge countdown keeps running.
- R3: An activate to a closed bank opens that bank and stores addr[12:0] as its row on `bank_rows` (bank n at bits 13n+12..13n). The stored row is kept until the next accepted activate to that bank.
- R4: A read or write to an open bank that is not closing pulses `col_valid` for one cycle. With it come `col_write` (1 = write), `col_bank` and `col_addr`. The column is addr[8:0] for x16, addr[9:0] for x8, and {addr[11], addr[9:0]} for x4.
- R5: A read or write with addr[10]=1 closes its bank after BURST_LEN further enabled edges. Until then the bank reads open, and any further read or write to it is refused with an error.
- R6: A precharge with addr[10]=1 closes all banks whatever `ba` holds. With addr[10]=0 it closes only bank `ba`. A precharge also cancels a pending auto-precharge.
- R7: A read or write to a closed bank, or an activate to an open bank, raises `cmd_err` for one cycle and changes no bank state or row.
- R8: Auto refresh is accepted only when every bank is closed. Otherwise it raises `cmd_err`.
- R9: While `cke` is low at an edge, no command is decoded and all bank state, including auto-precharge countdowns, holds.
- R10: A load-mode command changes no bank state and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the tracker |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row / column / control address |
| cmd_code | output | 3 | Registered accepted command code |
| cmd_err | output | 1 | One-cycle rule-violation flag |
| bank_open | output | 4 | Open flag per bank |
| bank_rows | output | 52 | Stored row per bank, 13 bits each |
| col_valid | output | 1 | Accepted read/write pulse |
| col_write | output | 1 | 1 for write, 0 for read |
| col_bank | output | 2 | Bank of the last accepted read/write |
| col_addr | output | COL_W | Column of the last accepted read/write |

## Verification
The bench builds the block with the x4 organisation and a burst length of four. With x4, the column packing that skips addr[10] and carries addr[11] becomes visible on the ports. The short burst lets a bench observe the auto-precharge countdown edge by edge. That includes a refused access while the bank is closing, a countdown that runs on while chip select is high, and one that stays frozen across several clock-enable-low cycles.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_RSV = 3'b110,
    CMD_NOP = 3'b111
  } cmd_t;

  function automatic int col_width(input int org);
    if (org == 4)      return 11;
    else if (org == 8) return 10;
    else               return 9;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
#(
  parameter int ORG_WIDTH = 16,
  parameter int ADDR_W    = 13,
  parameter int COL_W     = col_width(ORG_WIDTH)
) (
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output cmd_t              cmd,
  output logic [COL_W-1:0]  col
);

  always_comb begin
    if (!cke || cs_n) cmd = CMD_NOP;
    else              cmd = cmd_t'({ras_n, cas_n, we_n});
  end

  generate
    if (ORG_WIDTH == 4) begin : g_x4
      assign col = {addr[11], addr[9:0]};
    end else if (ORG_WIDTH == 8) begin : g_x8
      assign col = addr[9:0];
    end else begin : g_x16
      assign col = addr[8:0];
    end
  endgenerate

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             act_hit,
  input  logic             ap_hit,
  input  logic             pre_hit,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic             closing_o,
  output logic [ROW_W-1:0] row_o
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q,  row_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    cnt_d  = cnt_q;
    if (en) begin
      if (pre_hit) begin
        open_d = 1'b0;
        cnt_d  = '0;
      end else if (act_hit) begin
        open_d = 1'b1;
        row_d  = row_in;
      end else if (ap_hit) begin
        cnt_d = CNT_LOAD;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) open_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      row_q  <= row_d;
      cnt_q  <= cnt_d;
    end
  end

  assign open_o    = open_q;
  assign closing_o = (cnt_q != '0);
  assign row_o     = row_q;

  AST_ROW_HELD_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |=> $stable(row_q)); // R3

  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == CNT_ONE) |=> !open_q); // R5

  AST_FROZEN_NO_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(open_q) && $stable(cnt_q) && $stable(row_q))); // R9

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int ORG_WIDTH = 16,
  parameter int BURST_LEN = 8,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int COL_W     = col_width(ORG_WIDTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [2:0]                 cmd_code,
  output logic                       cmd_err,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_rows,
  output logic                       col_valid,
  output logic                       col_write,
  output logic [BA_W-1:0]            col_bank,
  output logic [COL_W-1:0]           col_addr
);

  localparam int AP_BIT = 10;

  cmd_t             cmd;
  logic [COL_W-1:0] col;
  logic [NUM_BANKS-1:0] open_v, closing_v;
  logic [NUM_BANKS-1:0] act_hit, ap_hit, pre_hit;
  logic sel_open, sel_closing, is_rw, rw_ok, act_ok, err_d;

  sdram_cmd_decode #(
    .ORG_WIDTH(ORG_WIDTH), .ADDR_W(ROW_W), .COL_W(COL_W)
  ) u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .cmd(cmd), .col(col)
  );

  assign sel_open    = open_v[ba];
  assign sel_closing = closing_v[ba];
  assign is_rw       = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign rw_ok       = is_rw && sel_open && !sel_closing;
  assign act_ok      = (cmd == CMD_ACT) && !sel_open;

  always_comb begin
    err_d = 1'b0;
    if (cmd == CMD_ACT && sel_open)                    err_d = 1'b1;
    if (is_rw && !rw_ok)                               err_d = 1'b1;
    if (cmd == CMD_REF && (open_v != '0))              err_d = 1'b1;
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign act_hit[b] = act_ok && (ba == BA_W'(b));
      assign ap_hit[b]  = rw_ok && addr[AP_BIT] && (ba == BA_W'(b));
      assign pre_hit[b] = (cmd == CMD_PRE) && (addr[AP_BIT] || ba == BA_W'(b));

      sdram_bank_slot #(
        .ROW_W(ROW_W), .BURST_LEN(BURST_LEN)
      ) u_slot (
        .clk(clk), .rst_n(rst_n), .en(cke),
        .act_hit(act_hit[b]), .ap_hit(ap_hit[b]), .pre_hit(pre_hit[b]),
        .row_in(addr),
        .open_o(open_v[b]), .closing_o(closing_v[b]),
        .row_o(bank_rows[b*ROW_W +: ROW_W])
      );
    end
  endgenerate

  logic [2:0]       cmd_q;
  logic             err_q, colv_q, colw_q;
  logic [BA_W-1:0]  colb_q;
  logic [COL_W-1:0] cola_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      err_q  <= 1'b0;
      colv_q <= 1'b0;
    end else begin
      cmd_q  <= cmd;
      err_q  <= err_d;
      colv_q <= rw_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colw_q <= 1'b0;
      colb_q <= '0;
      cola_q <= '0;
    end else if (rw_ok) begin
      colw_q <= (cmd == CMD_WR);
      colb_q <= ba;
      cola_q <= col;
    end
  end

  assign cmd_code  = cmd_q;
  assign cmd_err   = err_q;
  assign bank_open = open_v;
  assign col_valid = colv_q;
  assign col_write = colw_q;
  assign col_bank  = colb_q;
  assign col_addr  = cola_q;

  AST_CS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cs_n) |=> (!cmd_err && !col_valid && cmd_code == 3'b111)); // R2

  AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> bank_open[col_bank]); // R4

  AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && {ras_n, cas_n, we_n} == 3'b010 && addr[AP_BIT]) |=> (bank_open == '0)); // R6

  AST_REF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && {ras_n, cas_n, we_n} == 3'b001 && bank_open != '0) |=> cmd_err); // R8

  AST_ERR_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !col_valid); // R7

endmodule

// File: tb/sdram_cmd_tracker_test.sv
module sdram_cmd_tracker_test;

  localparam int ORG = 4;
  localparam int BL  = 4;
  localparam int CW  = 11;

  logic        clk = 1'b0;
  logic        rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [2:0]  cmd_code;
  logic        cmd_err, col_valid, col_write;
  logic [3:0]  bank_open;
  logic [51:0] bank_rows;
  logic [1:0]  col_bank;
  logic [CW-1:0] col_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sdram_cmd_tracker #(.ORG_WIDTH(ORG), .BURST_LEN(BL)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .cmd_err(cmd_err), .bank_open(bank_open), .bank_rows(bank_rows),
    .col_valid(col_valid), .col_write(col_write), .col_bank(col_bank),
    .col_addr(col_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic c, input logic [2:0] op,
                      input logic [1:0] b, input logic [12:0] a);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = op; ba = b; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  // fields: cke cs_n op[3] ba[2] addr[13] | err open[4] cmd[3] colv
  localparam int VW = 29;
  localparam logic [VW-1:0] VEC [13] = '{
    {1'b1, 1'b0, 3'b111, 2'd0, 13'h0000, 1'b0, 4'b0000, 3'b111, 1'b0},
    {1'b1, 1'b0, 3'b011, 2'd0, 13'h0123, 1'b0, 4'b0001, 3'b011, 1'b0},
    {1'b1, 1'b0, 3'b011, 2'd0, 13'h0FFF, 1'b1, 4'b0001, 3'b011, 1'b0},
    {1'b1, 1'b0, 3'b101, 2'd2, 13'h0000, 1'b1, 4'b0001, 3'b101, 1'b0},
    {1'b1, 1'b0, 3'b011, 2'd2, 13'h1ABC, 1'b0, 4'b0101, 3'b011, 1'b0},
    {1'b1, 1'b0, 3'b100, 2'd0, 13'h0A5A, 1'b0, 4'b0101, 3'b100, 1'b1},
    {1'b1, 1'b0, 3'b001, 2'd0, 13'h0000, 1'b1, 4'b0101, 3'b001, 1'b0},
    {1'b1, 1'b0, 3'b010, 2'd0, 13'h0000, 1'b0, 4'b0100, 3'b010, 1'b0},
    {1'b1, 1'b1, 3'b011, 2'd1, 13'h0777, 1'b0, 4'b0100, 3'b111, 1'b0},
    {1'b0, 1'b0, 3'b011, 2'd1, 13'h0777, 1'b0, 4'b0100, 3'b111, 1'b0},
    {1'b1, 1'b0, 3'b010, 2'd1, 13'h0400, 1'b0, 4'b0000, 3'b010, 1'b0},
    {1'b1, 1'b0, 3'b001, 2'd0, 13'h0000, 1'b0, 4'b0000, 3'b001, 1'b0},
    {1'b1, 1'b0, 3'b000, 2'd3, 13'h0033, 1'b0, 4'b0000, 3'b000, 1'b0}
  };

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1;
    {ras_n, cas_n, we_n} = 3'b111; ba = 2'd0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R1 reset cmd", 64'(cmd_code), 64'h7);
    chk("R7 reset err", 64'(cmd_err), 64'h0);
    chk("R3 reset open", 64'(bank_open), 64'h0);
    chk("R4 reset colv", 64'(col_valid), 64'h0);

    // table walk: R1 R2 R3 R6 R7 R8 R9 R10
    for (int i = 0; i < 13; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[28], v[27], v[26:24], v[23:22], v[21:9]);
      chk($sformatf("R7 R8 err vec%0d", i), 64'(cmd_err), 64'(v[8]));
      chk($sformatf("R3 R6 R9 R10 open vec%0d", i), 64'(bank_open), 64'(v[7:4]));
      chk($sformatf("R1 R2 cmd vec%0d", i), 64'(cmd_code), 64'(v[3:1]));
      chk($sformatf("R4 colv vec%0d", i), 64'(col_valid), 64'(v[0]));
    end

    // stored rows: refused activate left bank 0 row intact
    chk("R3 R7 row b0", 64'(bank_rows[12:0]), 64'h0123);
    chk("R3 row b2", 64'(bank_rows[38:26]), 64'h1ABC);
    chk("R9 R2 row b1 untouched", 64'(bank_rows[25:13]), 64'h0);
    // x4 column from the accepted write in the table
    chk("R4 col x4", 64'(col_addr), 64'h65A);
    chk("R4 col write", 64'(col_write), 64'h1);
    chk("R4 col bank", 64'(col_bank), 64'h0);

    // auto-precharge countdown, cs_n high during it
    step(1'b1, 1'b0, 3'b011, 2'd3, 13'h1555);
    step(1'b1, 1'b0, 3'b101, 2'd3, 13'h0403);
    chk("R4 rd colv", 64'(col_valid), 64'h1);
    chk("R4 rd col", 64'({col_write, col_bank, col_addr}), 64'({1'b0, 2'd3, 11'h003}));
    chk("R5 open after ap rd", 64'(bank_open), 64'h8);
    step(1'b1, 1'b1, 3'b101, 2'd3, 13'h0000);
    chk("R2 cs high ignored", 64'({cmd_err, col_valid}), 64'h0);
    chk("R5 open edge2", 64'(bank_open), 64'h8);
    step(1'b1, 1'b0, 3'b101, 2'd3, 13'h0000);
    chk("R5 rd to closing bank err", 64'(cmd_err), 64'h1);
    chk("R5 rd to closing no colv", 64'(col_valid), 64'h0);
    step(1'b1, 1'b0, 3'b111, 2'd0, 13'h0000);
    chk("R5 open edge4", 64'(bank_open), 64'h8);
    step(1'b1, 1'b0, 3'b111, 2'd0, 13'h0000);
    chk("R5 closed after BL", 64'(bank_open), 64'h0);

    // countdown frozen under cke low
    step(1'b1, 1'b0, 3'b011, 2'd1, 13'h0ABC);
    step(1'b1, 1'b0, 3'b100, 2'd1, 13'h0400);
    for (int j = 0; j < 5; j++) step(1'b0, 1'b0, 3'b111, 2'd0, 13'h0000);
    chk("R9 frozen open", 64'(bank_open), 64'h2);
    for (int j = 0; j < 3; j++) step(1'b1, 1'b0, 3'b111, 2'd0, 13'h0000);
    chk("R9 R5 open before last", 64'(bank_open), 64'h2);
    step(1'b1, 1'b0, 3'b111, 2'd0, 13'h0000);
    chk("R9 R5 closed after resume", 64'(bank_open), 64'h0);

    // single precharge cancels pending auto-precharge
    step(1'b1, 1'b0, 3'b011, 2'd0, 13'h0001);
    step(1'b1, 1'b0, 3'b011, 2'd2, 13'h0002);
    step(1'b1, 1'b0, 3'b101, 2'd2, 13'h0400);
    step(1'b1, 1'b0, 3'b010, 2'd2, 13'h0000);
    chk("R6 single pre", 64'(bank_open), 64'h1);
    step(1'b1, 1'b0, 3'b011, 2'd2, 13'h0003);
    for (int j = 0; j < 5; j++) step(1'b1, 1'b0, 3'b111, 2'd0, 13'h0000);
    chk("R6 ap cancelled", 64'(bank_open), 64'h5);
    chk("R3 reopen row", 64'(bank_rows[38:26]), 64'h0003);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule